// File: doc/BRIEF.md
# Byte/Word ALU with Status Flag Word

This block is the arithmetic and logic datapath of a 16-bit integer core. From two operands, an operation code, a byte/word select and the current flag word, it produces a result and an updated flag word in the same cycle. In byte mode only the low eight bits of each operand take part, and every flag refers to bit 7 as the top bit. In word mode every flag refers to the full operand width. The supported operations are add, add with carry-in, subtract, subtract with borrow-in, increment, decrement, compare, AND, OR, XOR and test.

The flag word packs six status flags and three control flags at fixed positions. The control flags pass straight through the block. Each operation class updates its own subset of the status flags. A result-write enable tells the register file whether the result is to be kept. Compare and test only set flags, so they leave this enable low.

An optional register holds the flag word. It is loaded from the computed flags when its write enable is high. Apart from that register the block has no state. It sits inside an execution stage that is already timed, so it has no valid/ready handshake: every output follows its inputs combinationally.

Top module: `flag_alu`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, INC=4, DEC=5, CMP=6, AND=7, OR=8, XOR=9, TEST=10. ADC adds and SBB subtracts the carry flag (bit 0) of the input flag word. INC and DEC add or subtract one and ignore operand b. In byte mode (byte_i=1) only bits 7:0 of each operand are used, and result bits above bit 7 are zero.
- R2: The carry flag (bit 0) is set on a carry out of, or a borrow into, the top bit of the selected width: bit 7 in byte mode, bit DATA_W-1 in word mode.
- R3: The auxiliary flag (bit 4) is set on a carry out of, or a borrow into, bit 3 for all arithmetic operations.
- R4: The parity flag (bit 2) is set when result bits 7:0 hold an even number of ones, in either width.
- R5: The zero flag (bit 6) is set when the width-masked result is zero. The sign flag (bit 7) equals the top bit of the result in the selected width.
- R6: The overflow flag (bit 11) is set when the signed result does not fit the selected width.
- R7: The output flag word keeps TF (bit 8), IF (bit 9) and DF (bit 10) from the input flag word. Bits 1, 3, 5 and 15:12 are reserved and are always zero on the output, whatever the input holds.
- R8: AND, OR, XOR and TEST clear the carry and overflow flags and keep the auxiliary flag from the input flag word.
- R9: INC and DEC update every status flag except the carry flag, which keeps its input value.
- R10: CMP and TEST drive wr_en_o low. Every other defined operation drives it high. CMP and TEST still output the difference or the conjunction on result_o.
- R11: An operation code of 11 to 15 gives a zero result and wr_en_o low, and passes the defined bits of the input flag word through unchanged.
- R12: With REG_FLAGS=1, flags_q_o is zero while rst_n is low. It loads flags_o on a rising clock edge when flag_we_i is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low reset of the flag register |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte width, 0 selects word width |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| flags_i | input | 16 | Current flag word |
| flag_we_i | input | 1 | Load enable of the flag register |
| result_o | output | DATA_W | Width-masked result |
| wr_en_o | output | 1 | Result-write enable |
| flags_o | output | 16 | Updated flag word (combinational) |
| flags_q_o | output | 16 | Registered flag word, or flags_o when REG_FLAGS=0 |

## Verification
The bench builds the block with DATA_W=16 and REG_FLAGS=1. Word width therefore places overflow and carry at bit 15, while byte mode tests them at bit 7 on the same hardware. With the register variant, both loading the flag word and holding it under a low enable can be observed at flags_q_o. The input flag words are chosen so that a kept flag (CF on increment, AF on logic operations) carries a value different from the one the operation would compute. Reserved input bits are set, so the masking shows at the output.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FLAG_W = 16;

  localparam int BIT_CF = 0;
  localparam int BIT_PF = 2;
  localparam int BIT_AF = 4;
  localparam int BIT_ZF = 6;
  localparam int BIT_SF = 7;
  localparam int BIT_TF = 8;
  localparam int BIT_IF = 9;
  localparam int BIT_DF = 10;
  localparam int BIT_OF = 11;

  localparam logic [FLAG_W-1:0] FLAG_DEF_MASK =
    FLAG_W'((1 << BIT_CF) | (1 << BIT_PF) | (1 << BIT_AF) | (1 << BIT_ZF) |
            (1 << BIT_SF) | (1 << BIT_TF) | (1 << BIT_IF) | (1 << BIT_DF) |
            (1 << BIT_OF));

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_CMP  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_TEST = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_fn_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cf_o,
  output logic              af_o,
  output logic              of_o
);
  localparam int EXT_W = DATA_W + 1;
  localparam int TOP   = DATA_W - 1;

  logic [EXT_W-1:0] ext_a, ext_b, ext_c, raw;
  logic             top_a, top_b, top_s;

  assign ext_a = {1'b0, a_i};
  assign ext_b = {1'b0, b_i};
  assign ext_c = {{DATA_W{1'b0}}, cin_i};

  // Operands arrive zero-extended in byte mode, so a borrow fills bit 8 upward.
  always_comb begin
    if (sub_i) raw = ext_a - ext_b - ext_c;
    else       raw = ext_a + ext_b + ext_c;
  end

  assign sum_o = raw[DATA_W-1:0];
  assign cf_o  = byte_i ? raw[8] : raw[DATA_W];
  assign af_o  = a_i[4] ^ b_i[4] ^ raw[4];

  assign top_a = byte_i ? a_i[7] : a_i[TOP];
  assign top_b = byte_i ? b_i[7] : b_i[TOP];
  assign top_s = byte_i ? raw[7] : raw[TOP];

  always_comb begin
    if (sub_i) of_o = (top_a != top_b) && (top_s != top_a);
    else       of_o = (top_a == top_b) && (top_s != top_a);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 16
) (
  input  alu_pkg::logic_fn_e fn_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output logic [DATA_W-1:0]  res_o
);
  import alu_pkg::*;

  always_comb begin
    unique case (fn_i)
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]          res_i,
  input  logic                       byte_i,
  input  logic                       valid_i,
  input  logic                       logic_i,
  input  logic                       keep_cf_i,
  input  logic                       cf_i,
  input  logic                       af_i,
  input  logic                       of_i,
  input  logic [alu_pkg::FLAG_W-1:0] flags_i,
  output logic [alu_pkg::FLAG_W-1:0] flags_o
);
  import alu_pkg::*;

  logic zf, sf, pf;

  assign zf = (res_i == '0);
  assign sf = byte_i ? res_i[7] : res_i[DATA_W-1];
  assign pf = ~^res_i[7:0];

  always_comb begin
    if (!valid_i) begin
      flags_o = flags_i & FLAG_DEF_MASK;
    end else begin
      flags_o         = '0;
      flags_o[BIT_TF] = flags_i[BIT_TF];
      flags_o[BIT_IF] = flags_i[BIT_IF];
      flags_o[BIT_DF] = flags_i[BIT_DF];
      flags_o[BIT_ZF] = zf;
      flags_o[BIT_SF] = sf;
      flags_o[BIT_PF] = pf;
      if (logic_i) begin
        flags_o[BIT_CF] = 1'b0;
        flags_o[BIT_OF] = 1'b0;
        flags_o[BIT_AF] = flags_i[BIT_AF];
      end else begin
        flags_o[BIT_CF] = keep_cf_i ? flags_i[BIT_CF] : cf_i;
        flags_o[BIT_OF] = of_i;
        flags_o[BIT_AF] = af_i;
      end
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int DATA_W    = 16,
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3:0]                 op_i,
  input  logic                       byte_i,
  input  logic [DATA_W-1:0]          a_i,
  input  logic [DATA_W-1:0]          b_i,
  input  logic [alu_pkg::FLAG_W-1:0] flags_i,
  input  logic                       flag_we_i,
  output logic [DATA_W-1:0]          result_o,
  output logic                       wr_en_o,
  output logic [alu_pkg::FLAG_W-1:0] flags_o,
  output logic [alu_pkg::FLAG_W-1:0] flags_q_o
);
  import alu_pkg::*;

  localparam int HI_W = DATA_W - 8;

  alu_op_e          op;
  logic             valid, is_logic, is_incdec, is_sub, use_cin, no_write;
  logic_fn_e        lfn;
  logic [DATA_W-1:0] opa, opb, arith_b;
  logic [DATA_W-1:0] sum, lres, raw_res, res;
  logic              cf, af, of;

  assign op = alu_op_e'(op_i);

  always_comb begin
    valid     = 1'b1;
    is_logic  = 1'b0;
    is_incdec = 1'b0;
    is_sub    = 1'b0;
    use_cin   = 1'b0;
    no_write  = 1'b0;
    lfn       = LG_AND;
    case (op)
      OP_ADD:  ;
      OP_ADC:  use_cin = 1'b1;
      OP_SUB:  is_sub = 1'b1;
      OP_SBB:  begin is_sub = 1'b1; use_cin = 1'b1; end
      OP_INC:  is_incdec = 1'b1;
      OP_DEC:  begin is_incdec = 1'b1; is_sub = 1'b1; end
      OP_CMP:  begin is_sub = 1'b1; no_write = 1'b1; end
      OP_AND:  is_logic = 1'b1;
      OP_OR:   begin is_logic = 1'b1; lfn = LG_OR; end
      OP_XOR:  begin is_logic = 1'b1; lfn = LG_XOR; end
      OP_TEST: begin is_logic = 1'b1; no_write = 1'b1; end
      default: valid = 1'b0;
    endcase
  end

  // Width selection: byte mode zero-extends the low byte of each operand.
  assign opa     = byte_i ? {{HI_W{1'b0}}, a_i[7:0]} : a_i;
  assign opb     = byte_i ? {{HI_W{1'b0}}, b_i[7:0]} : b_i;
  assign arith_b = is_incdec ? DATA_W'(1) : opb;

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i    (opa),
    .b_i    (arith_b),
    .cin_i  (use_cin & flags_i[BIT_CF]),
    .sub_i  (is_sub),
    .byte_i (byte_i),
    .sum_o  (sum),
    .cf_o   (cf),
    .af_o   (af),
    .of_o   (of)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .fn_i  (lfn),
    .a_i   (opa),
    .b_i   (opb),
    .res_o (lres)
  );

  assign raw_res = !valid ? '0 : (is_logic ? lres : sum);
  assign res     = byte_i ? {{HI_W{1'b0}}, raw_res[7:0]} : raw_res;

  alu_flags #(.DATA_W(DATA_W)) u_flags (
    .res_i     (res),
    .byte_i    (byte_i),
    .valid_i   (valid),
    .logic_i   (is_logic),
    .keep_cf_i (is_incdec),
    .cf_i      (cf),
    .af_i      (af),
    .of_i      (of),
    .flags_i   (flags_i),
    .flags_o   (flags_o)
  );

  assign result_o = res;
  assign wr_en_o  = valid & ~no_write;

  generate
    if (REG_FLAGS) begin : g_reg
      logic [FLAG_W-1:0] fq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         fq <= '0;
        else if (flag_we_i) fq <= flags_o;
      end
      assign flags_q_o = fq;
    end else begin : g_pass
      assign flags_q_o = flags_o;
    end
  endgenerate
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DATA_W    = 16,
  parameter bit REG_FLAGS = 1'b1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [3:0]                 op_i,
  input logic [DATA_W-1:0]          result_o,
  input logic                       wr_en_o,
  input logic [alu_pkg::FLAG_W-1:0] flags_i,
  input logic [alu_pkg::FLAG_W-1:0] flags_o,
  input logic                       flag_we_i,
  input logic [alu_pkg::FLAG_W-1:0] flags_q_o
);
  import alu_pkg::*;

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & ~FLAG_DEF_MASK) == '0);

  a_r7_ctrl_pass: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[BIT_DF:BIT_TF] == flags_i[BIT_DF:BIT_TF]);

  a_r8_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd7 && op_i <= 4'd10) |->
      (!flags_o[BIT_CF] && !flags_o[BIT_OF] && flags_o[BIT_AF] == flags_i[BIT_AF]));

  a_r9_keep_cf: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd4 || op_i == 4'd5) |-> flags_o[BIT_CF] == flags_i[BIT_CF]);

  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd6 || op_i == 4'd10) |-> !wr_en_o);

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i <= 4'd10) |-> flags_o[BIT_ZF] == (result_o == '0));

  a_r11_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 4'd10) |-> (!wr_en_o && result_o == '0));

  generate
    if (REG_FLAGS) begin : g_reg_chk
      a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(flags_q_o));
      a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> flags_q_o == $past(flags_o));
    end
  endgenerate
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W), .REG_FLAGS(REG_FLAGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_i      (op_i),
  .result_o  (result_o),
  .wr_en_o   (wr_en_o),
  .flags_i   (flags_i),
  .flags_o   (flags_o),
  .flag_we_i (flag_we_i),
  .flags_q_o (flags_q_o)
);

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;
  localparam int DATA_W = 16;
  localparam int NV     = 15;
  localparam int VW     = 4 + 1 + 16*5 + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic        byte_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0, flags_i = '0;
  logic        flag_we_i = 1'b0;
  logic [15:0] result_o, flags_o, flags_q_o;
  logic        wr_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flag_alu #(.DATA_W(DATA_W), .REG_FLAGS(1'b1)) i_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .byte_i(byte_i),
    .a_i(a_i), .b_i(b_i), .flags_i(flags_i), .flag_we_i(flag_we_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o),
    .flags_q_o(flags_q_o)
  );

  // {op, byte, a, b, flags_in, exp_result, exp_flags, exp_we}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd0,  1'b0, 16'h7FFF, 16'h0001, 16'h0000, 16'h8000, 16'h0894, 1'b1},
    {4'd0,  1'b1, 16'h00FF, 16'h0001, 16'h0000, 16'h0000, 16'h0055, 1'b1},
    {4'd1,  1'b0, 16'h1234, 16'h0001, 16'h0001, 16'h1236, 16'h0004, 1'b1},
    {4'd2,  1'b0, 16'h0000, 16'h0001, 16'h0000, 16'hFFFF, 16'h0095, 1'b1},
    {4'd3,  1'b1, 16'h0080, 16'h0000, 16'h0001, 16'h007F, 16'h0810, 1'b1},
    {4'd4,  1'b0, 16'hFFFF, 16'h1234, 16'h0000, 16'h0000, 16'h0054, 1'b1},
    {4'd5,  1'b1, 16'h0080, 16'h0000, 16'h0001, 16'h007F, 16'h0811, 1'b1},
    {4'd6,  1'b0, 16'h0005, 16'h0005, 16'h0700, 16'h0000, 16'h0744, 1'b0},
    {4'd7,  1'b0, 16'hF0F0, 16'hFF00, 16'h0811, 16'hF000, 16'h0094, 1'b1},
    {4'd8,  1'b1, 16'h1201, 16'h3402, 16'h0000, 16'h0003, 16'h0004, 1'b1},
    {4'd9,  1'b0, 16'hAAAA, 16'hAAAA, 16'h0001, 16'h0000, 16'h0044, 1'b1},
    {4'd10, 1'b0, 16'h8001, 16'h8000, 16'h0000, 16'h8000, 16'h0084, 1'b0},
    {4'd0,  1'b0, 16'h0001, 16'h0001, 16'hF02A, 16'h0002, 16'h0000, 1'b1},
    {4'd12, 1'b0, 16'h0001, 16'h0001, 16'hF7D5, 16'h0000, 16'h07D5, 1'b0},
    {4'd2,  1'b0, 16'h8000, 16'h0001, 16'h0000, 16'h7FFF, 16'h0814, 1'b1}
  };

  localparam string VREQ [NV] = '{
    "R6 R3 R4 R1", "R2 R1 R5", "R1 R3 R4", "R2 R3 R5", "R1 R6 R3",
    "R9 R5", "R9 R6", "R10 R7 R5", "R8 R4", "R1 R8",
    "R8 R5", "R10 R5", "R7", "R11", "R6 R3"
  };

  task automatic check16(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] v;
    repeat (3) @(negedge clk);
    check16("R12", "flags_q_o in reset", flags_q_o, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      op_i    = v[85:82];
      byte_i  = v[81];
      a_i     = v[80:65];
      b_i     = v[64:49];
      flags_i = v[48:33];
      #1;
      check16(VREQ[i], $sformatf("vec %0d result", i), result_o, v[32:17]);
      check16(VREQ[i], $sformatf("vec %0d flags", i), flags_o, v[16:1]);
      check16(VREQ[i], $sformatf("vec %0d wr_en", i), {15'b0, wr_en_o}, {15'b0, v[0]});
      @(negedge clk);
    end

    // R12: load, then hold under a low enable, then load again.
    op_i = 4'd0; byte_i = 1'b0; a_i = 16'h7FFF; b_i = 16'h0001; flags_i = 16'h0000;
    flag_we_i = 1'b1;
    @(negedge clk);
    check16("R12", "flags_q_o after load", flags_q_o, 16'h0894);
    flag_we_i = 1'b0; byte_i = 1'b1; a_i = 16'h00FF;
    @(negedge clk);
    @(negedge clk);
    check16("R12", "flags_q_o held", flags_q_o, 16'h0894);
    flag_we_i = 1'b1;
    @(negedge clk);
    check16("R12", "flags_q_o second load", flags_q_o, 16'h0055);
    flag_we_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check16("R12", "flags_q_o on reset", flags_q_o, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: byte mode ignores the upper operand bits.
    op_i = 4'd0; byte_i = 1'b1; a_i = 16'hAB10; b_i = 16'hCD20; flags_i = 16'h0000;
    #1;
    check16("R1", "byte add upper bits ignored", result_o, 16'h0030);
    check16("R4", "byte add flags", flags_o, 16'h0004);
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule